// File: doc/BRIEF.md
# Accumulator, Register File and Compare Datapath

This block is the 4-bit data path of a small accumulator machine. A single accumulator takes its value from a shared bus. Three sources can drive that bus: a literal from the program word, the read port of a four-word register file, and an external input port. The accumulator can also count up or down by one. A sequencer outside the block drives a strobe for each micro-operation. The block never decodes instructions.

Register addressing is indirect. A 4-bit pointer latch is loaded from the accumulator. Its upper pair of bits names the word to read and its lower pair names the word to write, so a program can read one register and write a different one without reloading the pointer. A magnitude comparator checks the accumulator against the bus. On command it latches one of three flags: less, equal or greater. The latched flags, combined with three jump-condition strobes, produce a segment-load strobe for the address logic. An output latch holds a copy of the accumulator for the outside world.

Top module: `acc_rf_datapath`

## Requirements
- R1: While `rst_ni` is low, the following are all zero: accumulator, pointer latch, every register word, flags, output latch and `seg_load_o`.
- R2: With `acc_load_i` high, the accumulator takes the bus value at the next rising edge.
- R3: `acc_inc_i` adds one and `acc_dec_i` subtracts one at the next edge. 15 wraps to 0, 0 wraps to 15, and no carry or borrow is kept.
- R4: `ptr_load_i` copies the accumulator into the pointer latch. Bits [3:2] are the read index and bits [1:0] are the write index. Codes 00, 01, 10 and 11 select words A, B, C and D.
- R5: `rf_write_i` stores the accumulator into the word named by the write index. The other words keep their values.
- R6: With `sel_reg_i` high, the bus carries the word named by the read index.
- R7: `sel_lit_i` puts `lit_i` on the bus and `sel_ext_i` puts `ext_i` on the bus. With no source enabled the bus reads 0.
- R8: `flag_latch_i` latches the comparison of the accumulator against the bus. The flag bits are bit 0 less, bit 1 equal and bit 2 greater, and exactly one of them is set. Without the strobe the flags hold.
- R9: `seg_load_o` is high exactly when (`jmp_lt_i` and less) or (`jmp_eq_i` and equal) or (`jmp_gt_i` and greater), using the latched flags.
- R10: `out_latch_i` copies the accumulator to `out_o` at the next edge. Otherwise `out_o` holds.
- R11: At most one bus source enable and at most one accumulator operation strobe are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lit_i | input | 4 | Program literal |
| ext_i | input | 4 | External input value |
| sel_lit_i | input | 1 | Drive literal onto bus |
| sel_reg_i | input | 1 | Drive register read word onto bus |
| sel_ext_i | input | 1 | Drive external input onto bus |
| acc_load_i | input | 1 | Load accumulator from bus |
| acc_inc_i | input | 1 | Increment accumulator |
| acc_dec_i | input | 1 | Decrement accumulator |
| ptr_load_i | input | 1 | Load register pointer latch from accumulator |
| rf_write_i | input | 1 | Write accumulator into register file |
| flag_latch_i | input | 1 | Latch compare flags |
| out_latch_i | input | 1 | Latch accumulator into output |
| jmp_lt_i | input | 1 | Jump-if-less condition strobe |
| jmp_eq_i | input | 1 | Jump-if-equal condition strobe |
| jmp_gt_i | input | 1 | Jump-if-greater condition strobe |
| acc_o | output | 4 | Accumulator value |
| flags_o | output | 3 | Latched flags {greater, equal, less} |
| out_o | output | 4 | Output latch |
| seg_load_o | output | 1 | Segment-load strobe |

## Verification
The checks assume that the sequencer never enables two bus sources at once. They also assume it never issues load, increment and decrement together. Under that assumption, the accumulator's next value is defined by a single strobe and the bus is never a merge of sources. The stimulus builds every cycle from one named micro-operation, so each cycle sets at most one source and one accumulator action. The jump-condition strobes are applied only to probe the segment strobe, and only after flags have been latched.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } flags_t;

  function automatic flags_t cmp_mag(input logic [31:0] a, input logic [31:0] b);
    flags_t f;
    f.lt = (a < b);
    f.eq = (a == b);
    f.gt = (a > b);
    return f;
  endfunction

endpackage

// File: rtl/dp_accumulator.sv
module dp_accumulator #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] bus_i,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] acc_o
);
  localparam logic [DW-1:0] One = DW'(1);

  logic [DW-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load_i)     acc_d = bus_i;
    else if (inc_i) acc_d = acc_q + One;  // modular wrap
    else if (dec_i) acc_d = acc_q - One;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;

  assign acc_o = acc_q;
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW   = 4,
  parameter int NREG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_load_i,
  input  logic [DW-1:0] ptr_src_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PW = 2 * AW;

  logic [PW-1:0] ptr_q;
  logic [AW-1:0] rd_idx, wr_idx;
  logic [DW-1:0] word_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= ptr_src_i[PW-1:0];

  // upper field reads, lower field writes
  assign rd_idx = ptr_q[PW-1:AW];
  assign wr_idx = ptr_q[AW-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                              word_q[g] <= '0;
      else if (wr_i && (wr_idx == AW'(g)))      word_q[g] <= wr_data_i;
  end

  assign rd_data_o = word_q[rd_idx];
endmodule

// File: rtl/dp_cmp_flags.sv
module dp_cmp_flags
  import acc_dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          latch_i,
  input  logic          jmp_lt_i,
  input  logic          jmp_eq_i,
  input  logic          jmp_gt_i,
  output flags_t        flags_o,
  output logic          seg_load_o
);
  flags_t cmp_w, flags_q;

  assign cmp_w = cmp_mag(32'(a_i), 32'(b_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      flags_q <= '0;
    else if (latch_i) flags_q <= cmp_w;

  assign flags_o    = flags_q;
  assign seg_load_o = (jmp_lt_i & flags_q.lt) | (jmp_eq_i & flags_q.eq) | (jmp_gt_i & flags_q.gt);
endmodule

// File: rtl/acc_rf_datapath.sv
module acc_rf_datapath
  import acc_dp_pkg::*;
#(
  parameter int DW   = 4,
  parameter int NREG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] lit_i,
  input  logic [DW-1:0] ext_i,
  input  logic          sel_lit_i,
  input  logic          sel_reg_i,
  input  logic          sel_ext_i,
  input  logic          acc_load_i,
  input  logic          acc_inc_i,
  input  logic          acc_dec_i,
  input  logic          ptr_load_i,
  input  logic          rf_write_i,
  input  logic          flag_latch_i,
  input  logic          out_latch_i,
  input  logic          jmp_lt_i,
  input  logic          jmp_eq_i,
  input  logic          jmp_gt_i,
  output logic [DW-1:0] acc_o,
  output logic [2:0]    flags_o,
  output logic [DW-1:0] out_o,
  output logic          seg_load_o
);
  logic [DW-1:0] bus_w, acc_w, rd_w, out_q;
  flags_t        flags_w;

  // priority-free bus: sources are exclusive by contract
  assign bus_w = ({DW{sel_lit_i}} & lit_i)
               | ({DW{sel_reg_i}} & rd_w)
               | ({DW{sel_ext_i}} & ext_i);

  dp_accumulator #(.DW(DW)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_w),
    .load_i(acc_load_i),
    .inc_i (acc_inc_i),
    .dec_i (acc_dec_i),
    .acc_o (acc_w)
  );

  dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_load_i(ptr_load_i),
    .ptr_src_i (acc_w),
    .wr_i      (rf_write_i),
    .wr_data_i (acc_w),
    .rd_data_o (rd_w)
  );

  dp_cmp_flags #(.DW(DW)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (acc_w),
    .b_i       (bus_w),
    .latch_i   (flag_latch_i),
    .jmp_lt_i  (jmp_lt_i),
    .jmp_eq_i  (jmp_eq_i),
    .jmp_gt_i  (jmp_gt_i),
    .flags_o   (flags_w),
    .seg_load_o(seg_load_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          out_q <= '0;
    else if (out_latch_i) out_q <= acc_w;

  assign acc_o   = acc_w;
  assign flags_o = flags_w;
  assign out_o   = out_q;
endmodule

// File: rtl/acc_rf_datapath_chk.sv
module acc_rf_datapath_chk #(
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] bus_i,
  input logic          sel_lit_i,
  input logic          sel_reg_i,
  input logic          sel_ext_i,
  input logic          acc_load_i,
  input logic          acc_inc_i,
  input logic          acc_dec_i,
  input logic          flag_latch_i,
  input logic          out_latch_i,
  input logic          jmp_lt_i,
  input logic          jmp_eq_i,
  input logic          jmp_gt_i,
  input logic [DW-1:0] acc_o,
  input logic [2:0]    flags_o,
  input logic [DW-1:0] out_o,
  input logic          seg_load_o
);
  assert_one_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_lit_i, sel_reg_i, sel_ext_i}));

  assert_one_acc_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_load_i, acc_inc_i, acc_dec_i}));

  assert_load_takes_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load_i |=> acc_o == $past(bus_i));

  assert_inc_wraps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_inc_i && !acc_load_i) |=> acc_o == DW'($past(acc_o) + DW'(1)));

  assert_dec_wraps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_dec_i && !acc_load_i && !acc_inc_i) |=> acc_o == DW'($past(acc_o) - DW'(1)));

  assert_flags_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_latch_i |=> $countones(flags_o) == 1);

  assert_flags_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_latch_i |=> $stable(flags_o));

  assert_seg_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(jmp_lt_i || jmp_eq_i || jmp_gt_i) |-> !seg_load_o);

  assert_seg_noflag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == 3'b000) |-> !seg_load_o);

  assert_out_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_latch_i |=> out_o == $past(acc_o));

  assert_out_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_latch_i |=> $stable(out_o));
endmodule

bind acc_rf_datapath acc_rf_datapath_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_i       (bus_w),
  .sel_lit_i   (sel_lit_i),
  .sel_reg_i   (sel_reg_i),
  .sel_ext_i   (sel_ext_i),
  .acc_load_i  (acc_load_i),
  .acc_inc_i   (acc_inc_i),
  .acc_dec_i   (acc_dec_i),
  .flag_latch_i(flag_latch_i),
  .out_latch_i (out_latch_i),
  .jmp_lt_i    (jmp_lt_i),
  .jmp_eq_i    (jmp_eq_i),
  .jmp_gt_i    (jmp_gt_i),
  .acc_o       (acc_o),
  .flags_o     (flags_o),
  .out_o       (out_o),
  .seg_load_o  (seg_load_o)
);

// File: tb/acc_rf_datapath_tb_top.sv
`timescale 1ns/1ps
module acc_rf_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] lit, ext, acc, outv;
  logic [2:0] flags;
  logic sl, sr, se, ld, inc, dec, pl, wr, fl, ol, jl, je, jg, seg;

  acc_rf_datapath dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lit_i(lit), .ext_i(ext),
    .sel_lit_i(sl), .sel_reg_i(sr), .sel_ext_i(se),
    .acc_load_i(ld), .acc_inc_i(inc), .acc_dec_i(dec),
    .ptr_load_i(pl), .rf_write_i(wr), .flag_latch_i(fl), .out_latch_i(ol),
    .jmp_lt_i(jl), .jmp_eq_i(je), .jmp_gt_i(jg),
    .acc_o(acc), .flags_o(flags), .out_o(outv), .seg_load_o(seg)
  );

  typedef struct packed {
    logic [3:0] lit, ext;
    logic sl, sr, se, ld, inc, dec, pl, wr, fl, ol;
  } ctl_t;

  typedef struct {
    string      tag;
    int         kind;   // 0 acc, 1 flags, 2 out, 3 seg
    logic [3:0] exp;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state from the requirements
  logic [3:0] m_acc, m_out, m_ptr;
  logic [3:0] m_rf [4];
  logic [2:0] m_flags;

  task automatic model_reset();
    m_acc = 0; m_out = 0; m_ptr = 0; m_flags = 0;
    for (int i = 0; i < 4; i++) m_rf[i] = 0;
  endtask

  task automatic push(string tag, int kind, logic [3:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic push_all(string tag);
    push(tag, 0, m_acc);
    push(tag, 1, {1'b0, m_flags});
    push(tag, 2, m_out);
  endtask

  task automatic step(ctl_t c, string tag);
    logic [3:0] bus, a0;
    @(negedge clk);
    {lit, ext, sl, sr, se, ld, inc, dec, pl, wr, fl, ol} = c;
    jl = 0; je = 0; jg = 0;
    bus = c.sl ? c.lit : c.sr ? m_rf[m_ptr[3:2]] : c.se ? c.ext : 4'd0;
    a0  = m_acc;
    @(posedge clk);
    #1;
    if (c.fl) m_flags = {a0 > bus, a0 == bus, a0 < bus};
    if (c.ol) m_out = a0;
    if (c.wr) m_rf[m_ptr[1:0]] = a0;
    if (c.pl) m_ptr = a0;
    if (c.ld) m_acc = bus;
    else if (c.inc) m_acc = a0 + 4'd1;
    else if (c.dec) m_acc = a0 - 4'd1;
    push_all(tag);
  endtask

  function automatic ctl_t z();
    return '0;
  endfunction

  task automatic t_lit(logic [3:0] v, string tag);
    ctl_t c = z(); c.sl = 1; c.lit = v; c.ld = 1; step(c, tag);
  endtask
  task automatic t_in(logic [3:0] v, string tag);
    ctl_t c = z(); c.se = 1; c.ext = v; c.ld = 1; step(c, tag);
  endtask
  task automatic t_ldreg(string tag);
    ctl_t c = z(); c.sr = 1; c.ld = 1; step(c, tag);
  endtask
  task automatic t_inc(string tag);
    ctl_t c = z(); c.inc = 1; step(c, tag);
  endtask
  task automatic t_dec(string tag);
    ctl_t c = z(); c.dec = 1; step(c, tag);
  endtask
  task automatic t_ptr(string tag);
    ctl_t c = z(); c.pl = 1; step(c, tag);
  endtask
  task automatic t_store(string tag);
    ctl_t c = z(); c.wr = 1; step(c, tag);
  endtask
  task automatic t_cmpl(logic [3:0] v, string tag);
    ctl_t c = z(); c.sl = 1; c.lit = v; c.fl = 1; step(c, tag);
  endtask
  task automatic t_cmpr(string tag);
    ctl_t c = z(); c.sr = 1; c.fl = 1; step(c, tag);
  endtask
  task automatic t_out(string tag);
    ctl_t c = z(); c.ol = 1; step(c, tag);
  endtask
  task automatic t_bare_load(string tag);
    ctl_t c = z(); c.ld = 1; c.lit = 4'hF; c.ext = 4'hF; step(c, tag);
  endtask

  task automatic probe_seg(logic l, logic e, logic g, string tag);
    jl = l; je = e; jg = g;
    #1;
    push(tag, 3, {3'b0, (l & m_flags[0]) | (e & m_flags[1]) | (g & m_flags[2])});
    #0.5;
    jl = 0; je = 0; jg = 0;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [3:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      case (it.kind)
        0: act = acc;
        1: act = {1'b0, flags};
        2: act = outv;
        default: act = {3'b0, seg};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    {lit, ext, sl, sr, se, ld, inc, dec, pl, wr, fl, ol} = '0;
    jl = 0; je = 0; jg = 0;
    model_reset();
    #12;
    push_all("R1 reset state");
    probe_seg(1, 1, 1, "R1 seg low in reset");
    @(negedge clk); rst_ni = 1;

    // R2 / R7 literal and external sources
    t_lit(4'd5, "R2 R7 load literal 5");
    t_in(4'hA, "R2 R7 load external A");
    t_bare_load("R7 no source reads zero");
    // R3 count and wrap
    t_lit(4'd14, "R2 literal 14");
    t_inc("R3 inc 14");
    t_inc("R3 inc 15 wraps");
    t_dec("R3 dec 0 wraps");
    t_dec("R3 dec 15");
    // R4 R5 R6: pointer read A, write B
    t_lit(4'b0001, "R4 ptr value rdA wrB");
    t_ptr("R4 load pointer");
    t_lit(4'd7, "R2 literal 7");
    t_store("R5 write B");
    t_ldreg("R6 read A untouched");
    t_lit(4'b0100, "R4 ptr value rdB wrA");
    t_ptr("R4 load pointer");
    t_ldreg("R6 read B");
    t_lit(4'd3, "R2 literal 3");
    t_store("R5 write A");
    t_lit(4'b1011, "R4 ptr value rdC wrD");
    t_ptr("R4 load pointer");
    t_store("R5 write D");
    t_ldreg("R6 read C untouched");
    t_lit(4'b1101, "R4 ptr value rdD wrB");
    t_ptr("R4 load pointer");
    t_ldreg("R6 read D");
    t_lit(4'b0111, "R4 ptr value rdB wrD");
    t_ptr("R4 load pointer");
    t_ldreg("R6 B kept after D write");
    t_lit(4'b0011, "R4 ptr value rdA wrD");
    t_ptr("R4 load pointer");
    t_ldreg("R6 read A");

    // R8 R9 compares
    t_lit(4'd5, "R2 literal 5");
    t_cmpl(4'd9, "R8 less");
    probe_seg(1, 0, 0, "R9 jl with less");
    probe_seg(0, 1, 1, "R9 je jg with less");
    t_inc("R8 flags hold");
    t_cmpl(4'd6, "R8 equal");
    probe_seg(0, 1, 0, "R9 je with equal");
    probe_seg(1, 0, 1, "R9 jl jg with equal");
    t_cmpl(4'd2, "R8 greater");
    probe_seg(0, 0, 1, "R9 jg with greater");
    probe_seg(1, 1, 0, "R9 jl je with greater");
    t_cmpr("R8 compare reg A 3");
    t_lit(4'd3, "R2 literal 3");
    t_cmpr("R8 compare reg equal");
    t_lit(4'd0, "R2 literal 0");
    t_cmpl(4'd15, "R8 less at extremes");
    t_lit(4'd15, "R2 literal 15");
    t_cmpl(4'd0, "R8 greater at extremes");

    // R10 output latch
    t_out("R10 capture 15");
    t_dec("R10 hold after dec");
    t_lit(4'd9, "R10 hold after load");
    t_out("R10 capture 9");
    t_in(4'd4, "R10 hold after input");

    // R1 reset mid-run
    @(negedge clk); rst_ni = 0;
    #1;
    model_reset();
    push_all("R1 reset mid-run");
    @(negedge clk); rst_ni = 1;
    t_ldreg("R1 register A cleared");
    t_lit(4'b0100, "R4 ptr rdB");
    t_ptr("R4 load pointer");
    t_ldreg("R1 register B cleared");

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule